// File: doc/BRIEF.md
# System Reset Cause Capture

This block merges every reset request in an always-on power domain into a single system reset output. It also keeps a record of why the last reset happened. The requests are:

- the power-on reset;
- an external reset pin;
- a software request bit;
- a low-frequency clock loss detector, gated by its own enable;
- a thermal shutdown input, gated by its own enable.

When one or more requests appear, a capture stage stores a single root cause. That record stays locked while any request is still active. Once every request has released, the record is copied into the status register. For one clock after that copy the capture stage is rearming. Any reset that arrives in that cycle is logged as a power-on reset, whatever its real origin.

Software reaches the block over a small word-addressed register bus with a single-cycle write strobe and a combinational read. Two wake flags are also held in the status register: one for wake from shutdown and one for a wake caused by an I/O event. Software clears both by writing the pad sleep release bit. A power-on reset clears all state. Other resets leave the status for the capture stage to overwrite.

Top module: `rstc_top`

## Requirements
- R1: While `por_i` is high, `sys_rst_o` is high. After a power-on reset, the status word (address 1) and the control word (address 0) read zero, with root cause 0 (power-on).
- R2: Writing 1 to control bit 0 (address 0) raises `sys_rst_o` on the next cycle. The bit clears itself on the following cycle. Once all requests release, the status records root cause 2 (system reset) in status bits [2:0] and sub-source 1 (software) in status bits [7:4], which reads as 0x012.
- R3: With control bit 1 (LF loss enable) set, `lf_loss_i` raises `sys_rst_o`, and the status afterwards reads root cause 2 with sub-source 2 (0x022). With the enable clear, `lf_loss_i` has no effect on `sys_rst_o` or on the status.
- R4: With control bit 2 (thermal enable) set, `tsd_i` raises `sys_rst_o` in the same cycle and holds it for as long as `tsd_i` stays high. The status afterwards reads root cause 2, sub-source 0 and thermal flag (status bit 3) set, which reads as 0x00A. With the enable clear, `tsd_i` is ignored.
- R5: `pin_rst_i` raises `sys_rst_o`, and the status afterwards reads root cause 1 (pin) with sub-source 0 and thermal flag 0 (0x001).
- R6: When several requests are active in the capture cycle, only one root cause is stored:
  - pin takes precedence over system reset;
  - among system sub-sources, software takes precedence over LF loss;
  - a pin-reset cause always carries sub-source 0;
  - root-cause codes above 2 and sub-source codes above 2 never appear.
- R7: While any request is active after a capture, the status keeps its previous value, and requests arriving in that time do not change the stored cause. The status changes only after all requests have released.
- R8: A request that is active in the single cycle right after the status copy is recorded as root cause 0 with sub-source 0 and thermal flag 0.
- R9: A pulse on `sd_wake_i` sets status bit 8, and a pulse on `io_wake_i` sets status bit 9. Writing 1 to bit 0 of address 2 (pad sleep release) clears both flags, and that bit reads back as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast always-on clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| pin_rst_i | input | 1 | External reset pin request |
| lf_loss_i | input | 1 | Low-frequency clock loss detected |
| tsd_i | input | 1 | Thermal shutdown event |
| sd_wake_i | input | 1 | Pulse: woke from shutdown |
| io_wake_i | input | 1 | Pulse: shutdown wake caused by an I/O event |
| reg_wen_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| sys_rst_o | output | 1 | System reset output |
| stat_cause_o | output | 3 | Stored root cause |
| stat_sub_o | output | 4 | Stored system-reset sub-source |
| stat_tsd_o | output | 1 | Stored thermal flag |
| stat_sdwake_o | output | 1 | Wake-from-shutdown flag |
| stat_iowake_o | output | 1 | I/O-event shutdown wake flag |

## Verification
The assertions watch several properties on every cycle:
- the stored record stays frozen while requests remain active after a capture;
- a request seen in the rearm cycle turns into a power-on capture;
- the software bit clears itself once reset is asserted;
- the pin and enabled thermal inputs always drive the reset output;
- stored codes stay legal.

Only the directed scenarios show the complete code values that land in status after each kind of reset. They also show the precedence between simultaneous requests and the exact cycle timing of the rearm window. Finally, they show that disabled LF-loss and thermal inputs leave both the output and the status untouched, and that the wake flags clear on a pad release write.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    // Root-cause codes stored in status [2:0]
    typedef enum logic [2:0] {
        CAUSE_POR = 3'd0,
        CAUSE_PIN = 3'd1,
        CAUSE_SYS = 3'd2
    } cause_e;

    // System-reset sub-source codes stored in status [7:4]
    typedef enum logic [3:0] {
        SUB_NONE   = 4'd0,
        SUB_SW     = 4'd1,
        SUB_LFLOSS = 4'd2
    } sub_e;

    typedef struct packed {
        cause_e cause;
        sub_e   sub;
        logic   tsd;
    } capt_t;

    typedef enum logic [1:0] {
        CAP_ARMED  = 2'd0,
        CAP_LOCKED = 2'd1,
        CAP_REARM  = 2'd2
    } cap_state_e;

    localparam capt_t CAPT_CLEAR = '{cause: CAUSE_POR, sub: SUB_NONE, tsd: 1'b0};

    // Register word addresses
    localparam int ADR_CTRL = 0;
    localparam int ADR_STAT = 1;
    localparam int ADR_PAD  = 2;

    // Control word bit positions
    localparam int CTRL_SW_BIT  = 0;
    localparam int CTRL_LF_BIT  = 1;
    localparam int CTRL_TSD_BIT = 2;
    localparam int CTRL_W       = 3;

    // Status word bit positions
    localparam int STAT_TSD_BIT = 3;
    localparam int STAT_SUB_LSB = 4;
    localparam int STAT_SDW_BIT = 8;
    localparam int STAT_IOW_BIT = 9;

    // Pick the single root cause among simultaneous requests
    function automatic capt_t rank_sources(input logic pin, input logic sw,
                                           input logic lf, input logic tsd);
        capt_t r;
        r = CAPT_CLEAR;
        if (pin) begin
            r.cause = CAUSE_PIN;
        end else if (sw || lf || tsd) begin
            r.cause = CAUSE_SYS;
            if (sw)      r.sub = SUB_SW;
            else if (lf) r.sub = SUB_LFLOSS;
        end
        r.tsd = tsd;
        return r;
    endfunction

    function automatic logic [31:0] pack_status(input capt_t c, input logic sdw,
                                                input logic iow);
        logic [31:0] w;
        w = '0;
        w[2:0]                        = c.cause;
        w[STAT_TSD_BIT]               = c.tsd;
        w[STAT_SUB_LSB +: 4]          = c.sub;
        w[STAT_SDW_BIT]               = sdw;
        w[STAT_IOW_BIT]               = iow;
        return w;
    endfunction

endpackage

// File: rtl/rstc_ctrl_regs.sv
module rstc_ctrl_regs
    import rstc_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              por,
    input  logic              wen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CTRL_W-1:0] wbits,
    input  logic              sys_rst,
    input  logic              sd_wake,
    input  logic              io_wake,
    output logic              sw_req,
    output logic              lf_en,
    output logic              tsd_en,
    output logic              pad_rel,
    output logic              sd_flag,
    output logic              io_flag
);

    logic wr_ctrl, wr_pad, flag_clr;

    assign wr_ctrl  = wen && (addr == ADDR_W'(ADR_CTRL));
    assign wr_pad   = wen && (addr == ADDR_W'(ADR_PAD));
    assign flag_clr = wr_pad && wbits[0];

    always_ff @(posedge clk) begin
        if (por) begin
            sw_req  <= 1'b0;
            lf_en   <= 1'b0;
            tsd_en  <= 1'b0;
            pad_rel <= 1'b0;
            sd_flag <= 1'b0;
            io_flag <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                sw_req <= wbits[CTRL_SW_BIT];
                lf_en  <= wbits[CTRL_LF_BIT];
                tsd_en <= wbits[CTRL_TSD_BIT];
            end
            // self-clear beats a write so a request cannot loop
            if (sw_req && sys_rst) sw_req <= 1'b0;
            if (wr_pad) pad_rel <= wbits[0];
            sd_flag <= (sd_flag && !flag_clr) || sd_wake;
            io_flag <= (io_flag && !flag_clr) || io_wake;
        end
    end

    assert_swreq_selfclear_R2: assert property (@(posedge clk) disable iff (por)
        (sw_req && sys_rst) |=> !sw_req);

    assert_wake_clear_R9: assert property (@(posedge clk) disable iff (por)
        (flag_clr && !sd_wake && !io_wake) |=> (!sd_flag && !io_flag));

endmodule

// File: rtl/rstc_src_arb.sv
module rstc_src_arb
    import rstc_pkg::*;
(
    input  logic  por,
    input  logic  pin,
    input  logic  sw_req,
    input  logic  lf_loss,
    input  logic  lf_en,
    input  logic  tsd,
    input  logic  tsd_en,
    output logic  src_any,
    output logic  sys_rst,
    output capt_t rank
);

    logic lf_act, tsd_act;

    assign lf_act  = lf_loss && lf_en;
    assign tsd_act = tsd && tsd_en;
    assign src_any = pin || sw_req || lf_act || tsd_act;
    assign sys_rst = por || src_any;
    assign rank    = rank_sources(pin, sw_req, lf_act, tsd_act);

endmodule

// File: rtl/rstc_capture.sv
module rstc_capture
    import rstc_pkg::*;
(
    input  logic  clk,
    input  logic  por,
    input  logic  src_any,
    input  capt_t rank,
    output capt_t stat
);

    cap_state_e state;
    capt_t      pend;

    always_ff @(posedge clk) begin
        if (por) begin
            state <= CAP_ARMED;
            pend  <= CAPT_CLEAR;
            stat  <= CAPT_CLEAR;
        end else begin
            unique case (state)
                CAP_ARMED: begin
                    if (src_any) begin
                        pend  <= rank;
                        state <= CAP_LOCKED;
                    end
                end
                CAP_LOCKED: begin
                    if (!src_any) begin
                        stat  <= pend;
                        state <= CAP_REARM;
                    end
                end
                CAP_REARM: begin
                    if (src_any) begin
                        pend  <= CAPT_CLEAR;
                        state <= CAP_LOCKED;
                    end else begin
                        state <= CAP_ARMED;
                    end
                end
                default: state <= CAP_ARMED;
            endcase
        end
    end

    assert_lock_hold_R7: assert property (@(posedge clk) disable iff (por)
        (state == CAP_LOCKED && src_any) |=> $stable(stat));

    assert_rearm_por_R8: assert property (@(posedge clk) disable iff (por)
        (state == CAP_REARM && src_any) |=> (state == CAP_LOCKED && pend.cause == CAUSE_POR));

    assert_code_legal_R6: assert property (@(posedge clk) disable iff (por)
        (stat.cause <= CAUSE_SYS) && (stat.sub <= SUB_LFLOSS));

    assert_pin_nosub_R6: assert property (@(posedge clk) disable iff (por)
        (stat.cause == CAUSE_PIN) |-> (stat.sub == SUB_NONE));

endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic              pin_rst_i,
    input  logic              lf_loss_i,
    input  logic              tsd_i,
    input  logic              sd_wake_i,
    input  logic              io_wake_i,
    input  logic              reg_wen_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              sys_rst_o,
    output logic [2:0]        stat_cause_o,
    output logic [3:0]        stat_sub_o,
    output logic              stat_tsd_o,
    output logic              stat_sdwake_o,
    output logic              stat_iowake_o
);

    logic  sw_req, lf_en, tsd_en, pad_rel, sd_flag, io_flag;
    logic  src_any, sys_rst;
    capt_t rank, stat;
    logic  unused_wdata;

    assign unused_wdata = ^reg_wdata_i[DATA_W-1:CTRL_W];

    rstc_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .por     (por_i),
        .wen     (reg_wen_i),
        .addr    (reg_addr_i),
        .wbits   (reg_wdata_i[CTRL_W-1:0]),
        .sys_rst (sys_rst),
        .sd_wake (sd_wake_i),
        .io_wake (io_wake_i),
        .sw_req  (sw_req),
        .lf_en   (lf_en),
        .tsd_en  (tsd_en),
        .pad_rel (pad_rel),
        .sd_flag (sd_flag),
        .io_flag (io_flag)
    );

    rstc_src_arb u_arb (
        .por     (por_i),
        .pin     (pin_rst_i),
        .sw_req  (sw_req),
        .lf_loss (lf_loss_i),
        .lf_en   (lf_en),
        .tsd     (tsd_i),
        .tsd_en  (tsd_en),
        .src_any (src_any),
        .sys_rst (sys_rst),
        .rank    (rank)
    );

    rstc_capture u_cap (
        .clk     (clk),
        .por     (por_i),
        .src_any (src_any),
        .rank    (rank),
        .stat    (stat)
    );

    assign sys_rst_o     = sys_rst;
    assign stat_cause_o  = stat.cause;
    assign stat_sub_o    = stat.sub;
    assign stat_tsd_o    = stat.tsd;
    assign stat_sdwake_o = sd_flag;
    assign stat_iowake_o = io_flag;

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_W'(ADR_CTRL)) begin
            reg_rdata_o[CTRL_SW_BIT]  = sw_req;
            reg_rdata_o[CTRL_LF_BIT]  = lf_en;
            reg_rdata_o[CTRL_TSD_BIT] = tsd_en;
        end else if (reg_addr_i == ADDR_W'(ADR_STAT)) begin
            reg_rdata_o = DATA_W'(pack_status(stat, sd_flag, io_flag));
        end else if (reg_addr_i == ADDR_W'(ADR_PAD)) begin
            reg_rdata_o[0] = pad_rel;
        end
    end

    assert_tsd_holds_R4: assert property (@(posedge clk) disable iff (por_i)
        (tsd_en && tsd_i) |-> sys_rst_o);

    assert_pin_reset_R5: assert property (@(posedge clk) disable iff (por_i)
        pin_rst_i |-> sys_rst_o);

endmodule

// File: tb/rstc_top_tb.sv
module rstc_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    logic              clk = 1'b0;
    logic              por_i = 1'b1;
    logic              pin_rst_i = 1'b0;
    logic              lf_loss_i = 1'b0;
    logic              tsd_i = 1'b0;
    logic              sd_wake_i = 1'b0;
    logic              io_wake_i = 1'b0;
    logic              reg_wen_i = 1'b0;
    logic [ADDR_W-1:0] reg_addr_i = '0;
    logic [DATA_W-1:0] reg_wdata_i = '0;
    logic [DATA_W-1:0] reg_rdata_o;
    logic              sys_rst_o;
    logic [2:0]        stat_cause_o;
    logic [3:0]        stat_sub_o;
    logic              stat_tsd_o;
    logic              stat_sdwake_o;
    logic              stat_iowake_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstc_top #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .por_i(por_i), .pin_rst_i(pin_rst_i), .lf_loss_i(lf_loss_i),
        .tsd_i(tsd_i), .sd_wake_i(sd_wake_i), .io_wake_i(io_wake_i),
        .reg_wen_i(reg_wen_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .sys_rst_o(sys_rst_o), .stat_cause_o(stat_cause_o),
        .stat_sub_o(stat_sub_o), .stat_tsd_o(stat_tsd_o),
        .stat_sdwake_o(stat_sdwake_o), .stat_iowake_o(stat_iowake_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_addr_i  = ADDR_W'(a);
        reg_wdata_i = d;
        reg_wen_i   = 1'b1;
        @(negedge clk);
        reg_wen_i   = 1'b0;
        reg_wdata_i = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr_i = ADDR_W'(a);
        #1;
        d = reg_rdata_o;
    endtask

    task automatic t_reset_R1();
        logic [31:0] d;
        por_i = 1'b1;
        step(2);
        chk("R1", "sys_rst during por", 32'(sys_rst_o), 32'd1);
        por_i = 1'b0;
        step(1);
        chk("R1", "sys_rst after por", 32'(sys_rst_o), 32'd0);
        rd(1, d); chk("R1", "status after por", d, 32'h0);
        rd(0, d); chk("R1", "control after por", d, 32'h0);
    endtask

    task automatic t_sw_R2();
        logic [31:0] d;
        wr(0, 32'h1);
        chk("R2", "sys_rst after sw write", 32'(sys_rst_o), 32'd1);
        step(1);
        rd(0, d); chk("R2", "sw bit self-cleared", d, 32'h0);
        chk("R2", "sys_rst released", 32'(sys_rst_o), 32'd0);
        step(3);
        rd(1, d); chk("R2", "status after sw reset", d, 32'h012);
    endtask

    task automatic t_lf_R3();
        logic [31:0] d;
        wr(0, 32'h0);
        lf_loss_i = 1'b1;
        step(4);
        chk("R3", "sys_rst with lf disabled", 32'(sys_rst_o), 32'd0);
        rd(1, d); chk("R3", "status unchanged lf disabled", d, 32'h012);
        lf_loss_i = 1'b0;
        wr(0, 32'h2);
        lf_loss_i = 1'b1;
        step(1);
        chk("R3", "sys_rst on lf loss", 32'(sys_rst_o), 32'd1);
        step(2);
        lf_loss_i = 1'b0;
        step(3);
        rd(1, d); chk("R3", "status after lf loss", d, 32'h022);
    endtask

    task automatic t_tsd_R4();
        logic [31:0] d;
        logic held;
        wr(0, 32'h0);
        tsd_i = 1'b1;
        step(3);
        chk("R4", "sys_rst with tsd disabled", 32'(sys_rst_o), 32'd0);
        rd(1, d); chk("R4", "status unchanged tsd disabled", d, 32'h022);
        tsd_i = 1'b0;
        wr(0, 32'h4);
        tsd_i = 1'b1;
        #1;
        held = sys_rst_o;
        for (int i = 0; i < 5; i++) begin
            step(1);
            held = held & sys_rst_o;
        end
        chk("R4", "sys_rst held during tsd", 32'(held), 32'd1);
        tsd_i = 1'b0;
        #1;
        chk("R4", "sys_rst released with tsd", 32'(sys_rst_o), 32'd0);
        step(3);
        rd(1, d); chk("R4", "status after thermal", d, 32'h00A);
        wr(0, 32'h0);
    endtask

    task automatic t_pin_R5();
        logic [31:0] d;
        pin_rst_i = 1'b1;
        #1;
        chk("R5", "sys_rst on pin", 32'(sys_rst_o), 32'd1);
        step(2);
        pin_rst_i = 1'b0;
        step(3);
        rd(1, d); chk("R5", "status after pin reset", d, 32'h001);
    endtask

    task automatic t_prio_R6();
        logic [31:0] d;
        wr(0, 32'h2);
        pin_rst_i = 1'b1;
        lf_loss_i = 1'b1;
        step(2);
        pin_rst_i = 1'b0;
        lf_loss_i = 1'b0;
        step(3);
        rd(1, d); chk("R6", "pin beats lf loss", d, 32'h001);
        wr(0, 32'h3);
        lf_loss_i = 1'b1;
        step(1);
        lf_loss_i = 1'b0;
        step(3);
        rd(1, d); chk("R6", "sw beats lf loss", d, 32'h012);
    endtask

    task automatic t_lock_R7();
        logic [31:0] d;
        wr(0, 32'h2);
        pin_rst_i = 1'b1;
        step(1);
        lf_loss_i = 1'b1;
        step(2);
        pin_rst_i = 1'b0;
        step(2);
        rd(1, d); chk("R7", "status held while locked", d, 32'h012);
        lf_loss_i = 1'b0;
        step(3);
        rd(1, d); chk("R7", "first cause kept after lock", d, 32'h001);
    endtask

    task automatic t_rearm_R8();
        logic [31:0] d;
        lf_loss_i = 1'b1;
        step(1);
        lf_loss_i = 1'b0;
        step(1);
        rd(1, d); chk("R8", "status copied before window", d, 32'h022);
        pin_rst_i = 1'b1;
        step(1);
        pin_rst_i = 1'b0;
        step(3);
        rd(1, d); chk("R8", "reset in rearm window logged as por", d, 32'h000);
        wr(0, 32'h0);
    endtask

    task automatic t_wake_R9();
        logic [31:0] d;
        sd_wake_i = 1'b1;
        step(1);
        sd_wake_i = 1'b0;
        io_wake_i = 1'b1;
        step(1);
        io_wake_i = 1'b0;
        rd(1, d); chk("R9", "wake flags set", d, 32'h300);
        wr(2, 32'h1);
        rd(1, d); chk("R9", "wake flags cleared", d, 32'h000);
        rd(2, d); chk("R9", "pad release readback", d, 32'h1);
    endtask

    task automatic t_por_again_R1();
        logic [31:0] d;
        pin_rst_i = 1'b1;
        step(1);
        pin_rst_i = 1'b0;
        step(3);
        rd(1, d); chk("R1", "pin status before por", d, 32'h001);
        por_i = 1'b1;
        step(2);
        por_i = 1'b0;
        step(1);
        rd(1, d); chk("R1", "por clears status", d, 32'h000);
        rd(2, d); chk("R1", "por clears pad release", d, 32'h0);
    endtask

    initial begin
        @(negedge clk);
        t_reset_R1();
        t_sw_R2();
        t_lf_R3();
        t_tsd_R4();
        t_pin_R5();
        t_prio_R6();
        t_lock_R7();
        t_rearm_R8();
        t_wake_R9();
        t_por_again_R1();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule